// File: doc/BRIEF.md
# DMA Destination Address Generator with Alignment Stepping

This block produces the destination address and the size of each beat for one DMA channel. Software programs a 32-bit start address through a register port with byte-lane enables. It then starts the channel with a byte count, a nominal beat size and a direction. The direction is either ascending, or fixed for a single port that the channel writes again and again. While the channel runs, the block presents one beat at a time to a request/acknowledge/error handshake on the bus side.

Each beat is the largest power of two that fits three limits. It may not exceed the nominal size, it may not exceed the bytes still to be moved, and it must be naturally aligned at the current address. An unaligned start therefore begins with small beats and works up to the nominal size. The address register moves only when a beat is acknowledged. When a beat ends in an error, the register keeps the address of that beat and the channel stops. A 64-bit nominal size with a start address that is not a multiple of 8 is refused as a configuration error and is not downsized.

Top module: `dma_dst_addr_gen`

## Requirements
- R1: After reset the address register is 0, and `busy`, `req`, `done`, `cfg_err` and `xfer_err` are all 0.
- R2: While the channel is idle, a write with `wr_en` high replaces exactly the bytes of the address register whose bit in `wr_be` is set. Bit k of `wr_be` selects bits 8k+7..8k.
- R3: A register write made while `busy` is high leaves the address register unchanged.
- R4: Size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. Each beat's `req_size` is the largest code whose byte count meets three conditions: it is no greater than the nominal size, no greater than the bytes remaining, and it divides `req_addr`.
- R5: In ascending mode (`cfg_ascend` = 1), each acknowledged beat adds its byte count to the address register.
- R6: In fixed mode (`cfg_ascend` = 0), the address register keeps its value through the whole transfer, and every beat is sized by the alignment of that one address.
- R7: While `req` is high and neither `ack` nor `err` has arrived, `req_addr`, `req_size` and the address register stay unchanged.
- R8: A start with nominal size code 3 and an address whose low three bits are not all zero sets `cfg_err` in the next cycle and issues no request. `cfg_err` stays set until the next start.
- R9: When `err` answers a beat, the channel leaves `busy` in the next cycle and the address register holds that beat's address. `xfer_err` is set and stays set until the next start, and `done` is not raised.
- R10: `done` pulses for one cycle in the cycle after the acknowledge that brings the remaining count to zero. A start with a byte count of 0 pulses `done` in the next cycle and issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Address register write strobe |
| wr_be | input | 4 | Byte-lane enables for the write |
| wr_data | input | 32 | Write data |
| addr_q | output | 32 | Current address register value |
| start | input | 1 | Start pulse, taken only while idle |
| xfer_len | input | 16 | Byte count, sampled at start |
| cfg_size | input | 2 | Nominal beat size code, sampled at start |
| cfg_ascend | input | 1 | 1 = ascending, 0 = fixed address, sampled at start |
| busy | output | 1 | Channel active |
| done | output | 1 | One-cycle completion pulse |
| cfg_err | output | 1 | Sticky misaligned 64-bit configuration flag |
| xfer_err | output | 1 | Sticky bus error flag |
| req | output | 1 | Beat request |
| req_addr | output | 32 | Beat address |
| req_size | output | 2 | Beat size code |
| ack | input | 1 | Beat completed |
| err | input | 1 | Beat failed |

## Verification
A wrong remaining count or a wrong latched nominal size first shows as a `req_size` that breaks R4. That happens on the very next beat, or at the latest on the final beats, where the remaining-byte limit takes over. A wrong address advance shows at once as an off `req_addr` on the following beat. It also shows as a misaligned beat a few beats later, because the size choice is driven by the address's own low bits. A fault in error capture is seen one cycle after `err`, through `busy`, `xfer_err` and the held `addr_q`. The directed scenarios use unaligned, aligned, short-tail and fixed-address patterns, so that each of the three limits on beat size decides at least one beat.

// File: rtl/dag_pkg.sv
// Shared definitions for the DMA destination address generator.
// Assumes byte-addressed buses with beats of 1, 2, 4 or 8 bytes.
package dag_pkg;
    localparam logic [1:0] SZ_B8  = 2'd0;
    localparam logic [1:0] SZ_B16 = 2'd1;
    localparam logic [1:0] SZ_B32 = 2'd2;
    localparam logic [1:0] SZ_B64 = 2'd3;

    typedef enum logic {ST_IDLE, ST_ISSUE} dag_state_e;

    // Byte count of a size code.
    function automatic logic [3:0] size_bytes(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

    // Smaller of two size codes.
    function automatic logic [1:0] size_min(input logic [1:0] a, input logic [1:0] b);
        return (a < b) ? a : b;
    endfunction
endpackage

// File: rtl/dag_addr_reg.sv
// Address register with byte-lane software writes and a hardware advance.
// Assumes the advance and the software write never need to land in the same
// cycle: the write is blocked (lock) whenever the channel is busy.
module dag_addr_reg #(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW/8-1:0]   wr_be,
    input  logic [AW-1:0]     wr_data,
    input  logic              lock,
    input  logic              adv,
    input  logic [3:0]        step,
    output logic [AW-1:0]     addr
);
    localparam int LANES = AW / 8;

    logic [AW-1:0] merged;

    // Per-lane merge of write data into the current value.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*8 +: 8] = wr_be[g] ? wr_data[g*8 +: 8] : addr[g*8 +: 8];
    end

    // Register update: advance has priority, writes only when unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (adv) begin
            addr <= addr + AW'(step);
        end else if (wr_en && !lock) begin
            addr <= merged;
        end
    end
endmodule

// File: rtl/dag_size_sel.sv
// Beat size selection: the largest power of two allowed by the nominal size,
// the remaining byte count and the natural alignment of the address.
// Assumes LEN_W > 3 and a nonzero remaining count while in use.
module dag_size_sel #(
    parameter int LEN_W = 16
) (
    input  logic [2:0]       addr_lo,
    input  logic [LEN_W-1:0] remain,
    input  logic [1:0]       nominal,
    output logic [1:0]       beat
);
    import dag_pkg::*;

    logic [1:0] rem_code;
    logic [1:0] align_code;

    // Floor log2 of the remaining count, capped at the 8-byte code.
    always_comb begin
        if (|remain[LEN_W-1:3])   rem_code = SZ_B64;
        else if (remain[2])       rem_code = SZ_B32;
        else if (remain[1])       rem_code = SZ_B16;
        else                      rem_code = SZ_B8;
    end

    // Alignment code from the lowest set address bit.
    always_comb begin
        if (addr_lo[0])           align_code = SZ_B8;
        else if (addr_lo[1])      align_code = SZ_B16;
        else if (addr_lo[2])      align_code = SZ_B32;
        else                      align_code = SZ_B64;
    end

    // Combine the three limits.
    always_comb begin
        beat = size_min(size_min(nominal, rem_code), align_code);
    end
endmodule

// File: rtl/dag_ctrl.sv
// Channel sequencer: accepts start, validates the configuration, counts the
// remaining bytes and follows the beat handshake. err takes priority over ack.
// Assumes ack and err are only presented while req is high.
module dag_ctrl #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] xfer_len,
    input  logic [1:0]       cfg_size,
    input  logic             cfg_ascend,
    input  logic [2:0]       addr_lo,
    input  logic [1:0]       beat,
    input  logic             ack,
    input  logic             err,
    output logic             issuing,
    output logic [LEN_W-1:0] remain,
    output logic [1:0]       nom_sz,
    output logic             asc_q,
    output logic             adv,
    output logic             done,
    output logic             cfg_err,
    output logic             xfer_err
);
    import dag_pkg::*;

    dag_state_e       state;
    logic [LEN_W-1:0] beat_len;
    logic             good_ack;

    // Byte count of the current beat, widened to the counter.
    always_comb begin
        beat_len = LEN_W'(size_bytes(beat));
        good_ack = (state == ST_ISSUE) && ack && !err;
        issuing  = (state == ST_ISSUE);
        adv      = good_ack && asc_q;
    end

    // Sequencer state, counter and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            remain   <= '0;
            nom_sz   <= SZ_B8;
            asc_q    <= 1'b0;
            done     <= 1'b0;
            cfg_err  <= 1'b0;
            xfer_err <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        cfg_err  <= 1'b0;
                        xfer_err <= 1'b0;
                        if (cfg_size == SZ_B64 && addr_lo != 3'd0) begin
                            cfg_err <= 1'b1;
                        end else if (xfer_len == '0) begin
                            done <= 1'b1;
                        end else begin
                            state  <= ST_ISSUE;
                            remain <= xfer_len;
                            nom_sz <= cfg_size;
                            asc_q  <= cfg_ascend;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (err) begin
                        state    <= ST_IDLE;
                        xfer_err <= 1'b1;
                    end else if (good_ack) begin
                        remain <= remain - beat_len;
                        if (remain == beat_len) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dma_dst_addr_gen.sv
// DMA destination address generator, top level. Ties the address register,
// the beat size selector and the sequencer together and exposes the beat
// handshake. Request address and size are pure functions of registered state,
// so they hold steady until ack or err.
module dma_dst_addr_gen #(
    parameter int AW    = 32,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW/8-1:0]  wr_be,
    input  logic [AW-1:0]    wr_data,
    output logic [AW-1:0]    addr_q,
    input  logic             start,
    input  logic [LEN_W-1:0] xfer_len,
    input  logic [1:0]       cfg_size,
    input  logic             cfg_ascend,
    output logic             busy,
    output logic             done,
    output logic             cfg_err,
    output logic             xfer_err,
    output logic             req,
    output logic [AW-1:0]    req_addr,
    output logic [1:0]       req_size,
    input  logic             ack,
    input  logic             err
);
    import dag_pkg::*;

    logic             issuing;
    logic [LEN_W-1:0] remain;
    logic [1:0]       nom_sz;
    logic             asc_q;
    logic             adv;
    logic [1:0]       beat;

    dag_addr_reg #(.AW(AW)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .lock    (issuing),
        .adv     (adv),
        .step    (size_bytes(beat)),
        .addr    (addr_q)
    );

    dag_size_sel #(.LEN_W(LEN_W)) u_size (
        .addr_lo (addr_q[2:0]),
        .remain  (remain),
        .nominal (nom_sz),
        .beat    (beat)
    );

    dag_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .xfer_len   (xfer_len),
        .cfg_size   (cfg_size),
        .cfg_ascend (cfg_ascend),
        .addr_lo    (addr_q[2:0]),
        .beat       (beat),
        .ack        (ack),
        .err        (err),
        .issuing    (issuing),
        .remain     (remain),
        .nom_sz     (nom_sz),
        .asc_q      (asc_q),
        .adv        (adv),
        .done       (done),
        .cfg_err    (cfg_err),
        .xfer_err   (xfer_err)
    );

    // Drive the handshake outputs from registered state.
    always_comb begin
        busy     = issuing;
        req      = issuing;
        req_addr = addr_q;
        req_size = beat;
    end
endmodule

// File: rtl/dag_chk.sv
// Property checker for dma_dst_addr_gen, attached with bind below.
module dag_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req,
    input logic          ack,
    input logic          err,
    input logic          busy,
    input logic          done,
    input logic [AW-1:0] req_addr,
    input logic [1:0]    req_size,
    input logic [AW-1:0] addr_q,
    input logic [1:0]    nom_sz,
    input logic          asc_q
);
    // R4
    beat_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> ((req_addr[3:0] & ((4'd1 << req_size) - 4'd1)) == 4'd0));

    // R4
    beat_le_nominal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (req_size <= nom_sz));

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack && !err) |=> (req && $stable(req_addr) && $stable(req_size)));

    // R3
    busy_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ack) |=> $stable(addr_q));

    // R5
    ascend_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack && !err && asc_q) |=>
            (addr_q == $past(addr_q) + AW'(4'd1 << $past(req_size))));

    // R9
    err_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && err) |=> (!busy && !done && $stable(addr_q)));
endmodule

bind dma_dst_addr_gen dag_chk #(.AW(AW)) u_dag_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .ack      (ack),
    .err      (err),
    .busy     (busy),
    .done     (done),
    .req_addr (req_addr),
    .req_size (req_size),
    .addr_q   (addr_q),
    .nom_sz   (nom_sz),
    .asc_q    (asc_q)
);

// File: tb/test_dma_dst_addr_gen.sv
module test_dma_dst_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_be = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] addr_q;
    logic        start = 1'b0;
    logic [15:0] xfer_len = '0;
    logic [1:0]  cfg_size = '0;
    logic        cfg_ascend = 1'b0;
    logic        busy, done, cfg_err, xfer_err, req;
    logic [31:0] req_addr;
    logic [1:0]  req_size;
    logic        ack = 1'b0;
    logic        err = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dma_dst_addr_gen i_dma_dst_addr_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
        .addr_q(addr_q), .start(start), .xfer_len(xfer_len), .cfg_size(cfg_size),
        .cfg_ascend(cfg_ascend), .busy(busy), .done(done), .cfg_err(cfg_err),
        .xfer_err(xfer_err), .req(req), .req_addr(req_addr), .req_size(req_size),
        .ack(ack), .err(err)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic write_addr(input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_be = be; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_be = '0;
    endtask

    task automatic kick(input logic [15:0] len, input logic [1:0] sz, input logic asc);
        @(negedge clk);
        xfer_len = len; cfg_size = sz; cfg_ascend = asc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // One beat: checks address/size, holds a wait cycle (R7), then responds.
    task automatic beat(input logic [31:0] ea, input logic [1:0] es, input bit fail, input string tag);
        int w = 0;
        while (!req && w < 20) begin @(negedge clk); w++; end
        check(req == 1'b1, {tag, " req"}, 32'(req), 32'd1);
        check(req_addr == ea, {tag, " R5 req_addr"}, req_addr, ea);
        check(req_size == es, {tag, " R4 req_size"}, 32'(req_size), 32'(es));
        @(negedge clk);
        check(req_addr == ea && addr_q == ea, {tag, " R7 hold addr"}, req_addr, ea);
        check(req_size == es, {tag, " R7 hold size"}, 32'(req_size), 32'(es));
        if (fail) err = 1'b1; else ack = 1'b1;
        @(negedge clk);
        ack = 1'b0; err = 1'b0;
    endtask

    task automatic t_reset();
        check(addr_q == 32'd0, "R1 addr", addr_q, 32'd0);
        check({busy, req, done, cfg_err, xfer_err} == 5'd0, "R1 flags",
              32'({busy, req, done, cfg_err, xfer_err}), 32'd0);
    endtask

    task automatic t_lanes();
        write_addr(4'hF, 32'hAABBCCDD);
        check(addr_q == 32'hAABBCCDD, "R2 full write", addr_q, 32'hAABBCCDD);
        write_addr(4'b0010, 32'h11223344);
        check(addr_q == 32'hAABB33DD, "R2 byte lane 1", addr_q, 32'hAABB33DD);
        write_addr(4'b1100, 32'h55667788);
        check(addr_q == 32'h556633DD, "R2 upper half", addr_q, 32'h556633DD);
    endtask

    task automatic t_unaligned32();
        write_addr(4'hF, 32'h0000_1003);
        kick(16'd16, 2'd2, 1'b1);
        beat(32'h1003, 2'd0, 0, "R4 u32 b0");
        beat(32'h1004, 2'd2, 0, "R4 u32 b1");
        beat(32'h1008, 2'd2, 0, "R4 u32 b2");
        beat(32'h100C, 2'd2, 0, "R4 u32 b3");
        check(done == 1'b0, "R10 no early done", 32'(done), 32'd0);
        beat(32'h1010, 2'd1, 0, "R4 u32 b4");
        beat(32'h1012, 2'd0, 0, "R4 u32 b5");
        check(done == 1'b1 && busy == 1'b0, "R10 done pulse", 32'({done, busy}), 32'h2);
        check(addr_q == 32'h1013, "R5 final addr", addr_q, 32'h1013);
        @(negedge clk);
        check(done == 1'b0, "R10 done one cycle", 32'(done), 32'd0);
    endtask

    task automatic t_u16();
        write_addr(4'hF, 32'h0000_6001);
        kick(16'd5, 2'd1, 1'b1);
        beat(32'h6001, 2'd0, 0, "R4 u16 b0");
        beat(32'h6002, 2'd1, 0, "R4 u16 b1");
        beat(32'h6004, 2'd1, 0, "R4 u16 b2");
        check(addr_q == 32'h6006 && done, "R5 u16 end", addr_q, 32'h6006);
    endtask

    task automatic t_cfg64();
        write_addr(4'hF, 32'h0000_2001);
        kick(16'd8, 2'd3, 1'b1);
        check(cfg_err == 1'b1 && busy == 1'b0 && req == 1'b0, "R8 cfg_err",
              32'({cfg_err, busy, req}), 32'h4);
        check(addr_q == 32'h2001, "R8 addr kept", addr_q, 32'h2001);
        @(negedge clk);
        check(cfg_err == 1'b1, "R8 sticky", 32'(cfg_err), 32'd1);
        write_addr(4'hF, 32'h0000_3000);
        kick(16'd20, 2'd3, 1'b1);
        check(cfg_err == 1'b0, "R8 cleared", 32'(cfg_err), 32'd0);
        beat(32'h3000, 2'd3, 0, "R4 a64 b0");
        beat(32'h3008, 2'd3, 0, "R4 a64 b1");
        beat(32'h3010, 2'd2, 0, "R4 a64 tail");
        check(addr_q == 32'h3014 && done, "R10 a64 end", addr_q, 32'h3014);
    endtask

    task automatic t_fixed();
        write_addr(4'hF, 32'h0000_4002);
        kick(16'd6, 2'd2, 1'b0);
        beat(32'h4002, 2'd1, 0, "R6 fixed b0");
        beat(32'h4002, 2'd1, 0, "R6 fixed b1");
        beat(32'h4002, 2'd1, 0, "R6 fixed b2");
        check(addr_q == 32'h4002 && done, "R6 fixed end", addr_q, 32'h4002);
    endtask

    task automatic t_error();
        write_addr(4'hF, 32'h0000_5000);
        kick(16'd16, 2'd2, 1'b1);
        beat(32'h5000, 2'd2, 0, "R9 err b0");
        beat(32'h5004, 2'd2, 1, "R9 err b1");
        check(busy == 1'b0 && req == 1'b0, "R9 stopped", 32'({busy, req}), 32'd0);
        check(xfer_err == 1'b1 && done == 1'b0, "R9 flag", 32'({xfer_err, done}), 32'h2);
        check(addr_q == 32'h5004, "R9 fault addr", addr_q, 32'h5004);
        repeat (2) @(negedge clk);
        check(xfer_err == 1'b1 && addr_q == 32'h5004, "R9 sticky", addr_q, 32'h5004);
    endtask

    task automatic t_busy_write();
        write_addr(4'hF, 32'h0000_7000);
        kick(16'd8, 2'd2, 1'b1);
        write_addr(4'hF, 32'hDEADBEEF);
        check(addr_q == 32'h7000, "R3 write ignored", addr_q, 32'h7000);
        check(xfer_err == 1'b0, "R9 cleared on start", 32'(xfer_err), 32'd0);
        beat(32'h7000, 2'd2, 0, "R3 b0");
        beat(32'h7004, 2'd2, 0, "R3 b1");
        check(addr_q == 32'h7008 && done, "R3 end", addr_q, 32'h7008);
    endtask

    task automatic t_zero_len();
        write_addr(4'hF, 32'h0000_8000);
        kick(16'd0, 2'd2, 1'b1);
        check(done == 1'b1 && req == 1'b0 && busy == 1'b0, "R10 zero length",
              32'({done, req, busy}), 32'h4);
        @(negedge clk);
        check(done == 1'b0 && req == 1'b0, "R10 zero len idle", 32'({done, req}), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lanes();
        t_unaligned32();
        t_u16();
        t_cfg64();
        t_fixed();
        t_error();
        t_busy_write();
        t_zero_len();
        summary();
        $finish;
    end
endmodule